// File: doc/BRIEF.md
# External interrupt request controller

This block converts edges on external pins, and a timer event, into latched interrupt requests for a small 8-bit processor core. Five sources are handled: three general interrupt pins, a counter-0 pin, and one shared source. The shared source is either an internal timer event or an edge on a counter-1 pin. Every source has a request bit and an enable bit. The block drives a pending flag and the identity of the source to be serviced. Software uses a small register port to set the edge polarity, the pin routing and the shared-source choice, to set the enable bits, and to clear requests.

Each pin passes through a two-flop synchroniser. After that, a routing multiplexer and a polarity inversion produce an observed level for each source. Edge detection runs on that observed level, so a configuration change that moves the level from low to high looks the same as a real edge. Detected events are held in staging registers and only become request bits at the instruction-cycle latch points. The processor marks those points with a final-clock phase input and an instruction-start phase input. An acknowledge input clears the request of the source currently reported.

Top module: `eirq_ctrl`

## Requirements
- R1: Registers sit at address 0 (edge/route configuration), 1 (counter configuration), 2 (requests) and 3 (enables). After reset all four read 0 and irq_pend is low. With all pins low, no request is latched.
- R2: Bits 0, 1 and 2 of register 0 set the active edge of interrupt pins 0, 1 and 2 (request bits 0, 1, 2). A 0 selects the rising edge and a 1 the falling edge. The opposite edge raises no request.
- R3: Bit 4 of register 0 picks the input for interrupt 0 and bit 5 picks the input for interrupt 1. A 0 selects the primary pin (_a) and a 1 the alternate pin (_b). The pin that is not selected raises no request.
- R4: Bits [1:0] of register 1 set the counter-0 pin's active edge: 00 rising, 01 falling, 10 both edges, 11 no edge. The result goes to request bit 3.
- R5: Request bit 4 is the shared source. With bit 3 of register 0 at 0, it is set by a rising edge of tmr_evt. With that bit at 1, it is set by an edge on the counter-1 pin, and bit 2 of register 1 chooses that edge (0 rising, 1 falling). The source that is not selected raises no request.
- R6: A write to a polarity, routing, shared-source or counter-mode field that drives a source's observed level from low to high raises that source's request, even when no pin moved.
- R7: Events are latched at two points. An event detected before the cyc_last clock is latched at the end of that clock. An event detected during the cyc_last clock is latched at the end of the next cyc_start clock. When early_latch is high, such an event is latched at the end of the cyc_last clock instead.
- R8: A request bit stays set until software writes 0 to that bit in register 2. Writing 1 to a request bit has no effect.
- R9: Bit i of register 3 enables request bit i. irq_pend is high exactly when some enabled request is set. irq_id gives the lowest-numbered such source. Requests that are not enabled still read back in register 2.
- R10: irq_ack held high for one clock while irq_pend is high clears only the request named by irq_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_int0_a | input | 1 | Interrupt 0 primary pin |
| pin_int0_b | input | 1 | Interrupt 0 alternate pin |
| pin_int1_a | input | 1 | Interrupt 1 primary pin |
| pin_int1_b | input | 1 | Interrupt 1 alternate pin |
| pin_int2 | input | 1 | Interrupt 2 pin |
| pin_cnt0 | input | 1 | Counter-0 pin |
| pin_cnt1 | input | 1 | Counter-1 pin |
| tmr_evt | input | 1 | Internal timer event, already synchronous |
| cyc_last | input | 1 | High during the final clock of an instruction |
| cyc_start | input | 1 | High during the first clock of an instruction |
| early_latch | input | 1 | Latch final-clock events at the first point |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq_ack | input | 1 | Acknowledge of the reported source |
| irq_pend | output | 1 | An enabled request is set |
| irq_id | output | 3 | Lowest-numbered enabled pending source |

## Verification
A pin change needs two synchroniser clocks before it reaches the edge detector, and the staging register captures it at the third edge. A configuration write or a tmr_evt pulse is staged one or two edges after the write or pulse. A staged event becomes a request at the edge that ends the relevant phase clock. irq_pend, irq_id and reg_rdata follow the registers within the same cycle. The bench therefore drives every input at a falling edge and waits three falling edges before it issues a latch phase. It reads results 1 ns after a falling edge. In the latch-point tests it counts falling edges exactly, so that an event lands in the cyc_last clock and the request is checked both before and after the second latch point.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int NSRC = 5;
  localparam int IDW  = $clog2(NSRC);
  localparam int DW   = 8;
  localparam int AW   = 2;
  localparam int NPIN = 7;

  localparam logic [AW-1:0] A_EDGE = 2'd0;
  localparam logic [AW-1:0] A_CNT  = 2'd1;
  localparam logic [AW-1:0] A_REQ  = 2'd2;
  localparam logic [AW-1:0] A_EN   = 2'd3;

  localparam int S_INT0 = 0;
  localparam int S_INT1 = 1;
  localparam int S_INT2 = 2;
  localparam int S_CNT0 = 3;
  localparam int S_SHR  = 4;

  localparam int P_INT0A = 0;
  localparam int P_INT0B = 1;
  localparam int P_INT1A = 2;
  localparam int P_INT1B = 3;
  localparam int P_INT2  = 4;
  localparam int P_CNT0  = 5;
  localparam int P_CNT1  = 6;

  typedef enum logic [1:0] {
    CM_RISE = 2'b00,
    CM_FALL = 2'b01,
    CM_BOTH = 2'b10,
    CM_OFF  = 2'b11
  } cmode_e;

  typedef struct packed {
    logic [1:0] spare;
    logic       int1_alt;
    logic       int0_alt;
    logic       shr_pin;
    logic [2:0] int_fall;
  } edge_cfg_t;

  typedef struct packed {
    logic [4:0] spare;
    logic       cnt1_fall;
    cmode_e     cnt0_mode;
  } cnt_cfg_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic both_en,
  input  logic off,
  output logic ev
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  // the observed level already carries polarity, so a rise is the active edge
  always_comb begin
    if (off)          ev = 1'b0;
    else if (both_en) ev = lvl ^ prev_q;
    else              ev = lvl & ~prev_q;
  end
endmodule

// File: rtl/eirq_prio.sv
module eirq_prio #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  act,
  output logic          any,
  output logic [IW-1:0] id
);
  always_comb begin
    any = |act;
    id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) id = IW'(i);
    end
  end
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         cyc_last,
  input  logic         cyc_start,
  input  logic         early,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] req
);
  logic [N-1:0] pend_a, pend_b;
  logic [N-1:0] set_a, set_b, keep, pend_a_n, pend_b_n;

  always_comb begin
    set_a    = cyc_last  ? (pend_a | (early ? ev : '0)) : '0;
    set_b    = cyc_start ? pend_b : '0;
    keep     = ~(clr_we ? ~clr_data : '0) & ~ack_clr;
    pend_a_n = cyc_last ? '0 : (pend_a | ev);
    pend_b_n = (cyc_start ? '0 : pend_b) | ((cyc_last && !early) ? ev : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a <= '0;
      pend_b <= '0;
      req    <= '0;
    end else begin
      pend_a <= pend_a_n;
      pend_b <= pend_b_n;
      req    <= (req & keep) | set_a | set_b;
    end
  end

  // R7: a request bit only rises at one of the two latch points
  a_r7_set_at_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req & ~$past(req))) |-> $past(cyc_last || cyc_start));

  // R8: a request bit only drops after a register clear or an acknowledge
  a_r8_drop_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(req) & ~req)) |-> $past(clr_we || (|ack_clr)));

  // R10: an acknowledge clears at most one source
  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr));
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_int0_a,
  input  logic           pin_int0_b,
  input  logic           pin_int1_a,
  input  logic           pin_int1_b,
  input  logic           pin_int2,
  input  logic           pin_cnt0,
  input  logic           pin_cnt1,
  input  logic           tmr_evt,
  input  logic           cyc_last,
  input  logic           cyc_start,
  input  logic           early_latch,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           irq_ack,
  output logic           irq_pend,
  output logic [IDW-1:0] irq_id
);
  edge_cfg_t       edge_q;
  cnt_cfg_t        cnt_q;
  logic [NSRC-1:0] en_q;
  logic [NPIN-1:0] pin_raw, pin_s;
  logic [NSRC-1:0] lvl, both_v, off_v, ev, req, ack_clr;
  logic            clr_we;

  assign pin_raw = {pin_cnt1, pin_cnt0, pin_int2, pin_int1_b, pin_int1_a,
                    pin_int0_b, pin_int0_a};

  eirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (pin_raw), .dout (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      cnt_q  <= '0;
      en_q   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_EDGE:  edge_q <= edge_cfg_t'(reg_wdata);
        A_CNT:   cnt_q  <= cnt_cfg_t'(reg_wdata);
        A_EN:    en_q   <= reg_wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  assign clr_we = reg_we && (reg_addr == A_REQ);

  // observed level per source: routing, then polarity
  always_comb begin
    lvl[S_INT0] = (edge_q.int0_alt ? pin_s[P_INT0B] : pin_s[P_INT0A]) ^ edge_q.int_fall[0];
    lvl[S_INT1] = (edge_q.int1_alt ? pin_s[P_INT1B] : pin_s[P_INT1A]) ^ edge_q.int_fall[1];
    lvl[S_INT2] = pin_s[P_INT2] ^ edge_q.int_fall[2];
    lvl[S_CNT0] = pin_s[P_CNT0] ^ (cnt_q.cnt0_mode == CM_FALL);
    lvl[S_SHR]  = edge_q.shr_pin ? (pin_s[P_CNT1] ^ cnt_q.cnt1_fall) : tmr_evt;
    both_v         = '0;
    off_v          = '0;
    both_v[S_CNT0] = (cnt_q.cnt0_mode == CM_BOTH);
    off_v[S_CNT0]  = (cnt_q.cnt0_mode == CM_OFF);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_edge
    eirq_edge u_edge (
      .clk (clk), .rst_n (rst_n), .lvl (lvl[i]),
      .both_en (both_v[i]), .off (off_v[i]), .ev (ev[i])
    );
  end

  eirq_latch #(.N(NSRC)) u_latch (
    .clk (clk), .rst_n (rst_n), .ev (ev),
    .cyc_last (cyc_last), .cyc_start (cyc_start), .early (early_latch),
    .clr_we (clr_we), .clr_data (reg_wdata[NSRC-1:0]),
    .ack_clr (ack_clr), .req (req)
  );

  eirq_prio #(.N(NSRC), .IW(IDW)) u_prio (
    .act (req & en_q), .any (irq_pend), .id (irq_id)
  );

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      ack_clr[i] = irq_ack && irq_pend && (irq_id == IDW'(i));
    end
  end

  always_comb begin
    case (reg_addr)
      A_EDGE:  reg_rdata = edge_q;
      A_CNT:   reg_rdata = cnt_q;
      A_REQ:   reg_rdata = {{(DW-NSRC){1'b0}}, req};
      default: reg_rdata = {{(DW-NSRC){1'b0}}, en_q};
    endcase
  end

  // R9: the reported source is always a real one
  a_r9_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (irq_id < IDW'(NSRC)));

  // R9: nothing is pending while every enable is off
  a_r9_pend_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (|en_q));
endmodule

// File: tb/eirq_ctrl_bench.sv
`timescale 1ns/1ps
module eirq_ctrl_bench;
  import eirq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_int0_a = 0, pin_int0_b = 0, pin_int1_a = 0, pin_int1_b = 0;
  logic pin_int2 = 0, pin_cnt0 = 0, pin_cnt1 = 0, tmr_evt = 0;
  logic cyc_last = 0, cyc_start = 0, early_latch = 0;
  logic [1:0] reg_addr = '0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_ack = 0;
  logic irq_pend;
  logic [2:0] irq_id;

  always #2.5 clk = ~clk;

  eirq_ctrl u_eirq_ctrl (
    .clk (clk), .rst_n (rst_n),
    .pin_int0_a (pin_int0_a), .pin_int0_b (pin_int0_b),
    .pin_int1_a (pin_int1_a), .pin_int1_b (pin_int1_b),
    .pin_int2 (pin_int2), .pin_cnt0 (pin_cnt0), .pin_cnt1 (pin_cnt1),
    .tmr_evt (tmr_evt), .cyc_last (cyc_last), .cyc_start (cyc_start),
    .early_latch (early_latch), .reg_addr (reg_addr), .reg_we (reg_we),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_ack (irq_ack),
    .irq_pend (irq_pend), .irq_id (irq_id)
  );

  typedef struct {
    string      tag;
    bit         kind;
    logic [7:0] exp;
  } item_t;

  item_t sb[$];
  event  chk_ev;
  int    vec = 0;
  int    bad = 0;
  bit    done = 0;

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it  = sb.pop_front();
        got = it.kind ? {4'b0, irq_pend, irq_id} : reg_rdata;
        vec++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic chk_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    sb.push_back('{tag: tag, kind: 1'b0, exp: exp});
    -> chk_ev;
  endtask

  task automatic chk_irq(input string tag, input logic p, input logic [2:0] id);
    @(negedge clk);
    #1;
    sb.push_back('{tag: tag, kind: 1'b1, exp: {4'b0, p, id}});
    -> chk_ev;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic latch();
    @(negedge clk); cyc_last = 1;
    @(negedge clk); cyc_last = 0; cyc_start = 1;
    @(negedge clk); cyc_start = 0;
  endtask

  task automatic step();
    settle();
    latch();
  endtask

  task automatic clr_all();
    wr(A_REQ, 8'h00);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    chk_reg("R1 edge reg after reset", A_EDGE, 8'h00);
    chk_reg("R1 counter reg after reset", A_CNT, 8'h00);
    chk_reg("R1 request reg after reset", A_REQ, 8'h00);
    chk_reg("R1 enable reg after reset", A_EN, 8'h00);
    chk_irq("R1 no pending after reset", 1'b0, 3'd0);
    latch();
    chk_reg("R1 idle pins latch nothing", A_REQ, 8'h00);

    // interrupt 0 rising, pending report, clearing
    @(negedge clk) pin_int0_a = 1; step();
    chk_reg("R2 int0 rising edge", A_REQ, 8'h01);
    wr(A_EN, 8'h01);
    chk_irq("R9 int0 pending when enabled", 1'b1, 3'd0);
    wr(A_REQ, 8'hFF);
    chk_reg("R8 writing one keeps request", A_REQ, 8'h01);
    wr(A_REQ, 8'h1E);
    chk_reg("R8 writing zero clears request", A_REQ, 8'h00);
    chk_irq("R9 no pending after clear", 1'b0, 3'd0);

    // interrupt 0 falling
    wr(A_EDGE, 8'h01); step();
    chk_reg("R2 polarity switch to low level raises nothing", A_REQ, 8'h00);
    @(negedge clk) pin_int0_a = 0; step();
    chk_reg("R2 int0 falling edge", A_REQ, 8'h01);
    clr_all();
    @(negedge clk) pin_int0_a = 1; step();
    chk_reg("R2 rising ignored in falling mode", A_REQ, 8'h00);

    // routing of interrupt 1
    wr(A_EDGE, 8'h21); step();
    @(negedge clk) pin_int1_a = 1; step();
    chk_reg("R3 unselected primary pin ignored", A_REQ, 8'h00);
    @(negedge clk) pin_int1_b = 1; step();
    chk_reg("R3 alternate pin feeds int1", A_REQ, 8'h02);
    clr_all();

    // polarity change as an apparent edge
    wr(A_EDGE, 8'h25); step();
    chk_reg("R6 int2 polarity change raises request", A_REQ, 8'h04);
    clr_all();

    // counter-0 modes
    @(negedge clk) pin_cnt0 = 1; step();
    chk_reg("R4 cnt0 rising", A_REQ, 8'h08);
    clr_all();
    wr(A_CNT, 8'h02); step();
    chk_reg("R4 switch to both-edge mode no artefact", A_REQ, 8'h00);
    @(negedge clk) pin_cnt0 = 0; step();
    chk_reg("R4 both mode falling", A_REQ, 8'h08);
    clr_all();
    @(negedge clk) pin_cnt0 = 1; step();
    chk_reg("R4 both mode rising", A_REQ, 8'h08);
    clr_all();
    wr(A_CNT, 8'h03); step();
    @(negedge clk) pin_cnt0 = 0; step();
    chk_reg("R4 off mode ignores edges", A_REQ, 8'h00);
    wr(A_CNT, 8'h01); step();
    chk_reg("R6 cnt0 mode change raises request", A_REQ, 8'h08);
    clr_all();
    @(negedge clk) pin_cnt0 = 1; step();
    chk_reg("R4 falling mode ignores rise", A_REQ, 8'h00);
    @(negedge clk) pin_cnt0 = 0; step();
    chk_reg("R4 falling mode", A_REQ, 8'h08);
    clr_all();

    // shared source
    @(negedge clk) tmr_evt = 1;
    @(negedge clk) tmr_evt = 0; step();
    chk_reg("R5 timer event on shared source", A_REQ, 8'h10);
    clr_all();
    @(negedge clk) pin_cnt1 = 1; step();
    chk_reg("R5 cnt1 ignored while timer selected", A_REQ, 8'h00);
    @(negedge clk) pin_cnt1 = 0; step();
    wr(A_CNT, 8'h05); step();
    chk_reg("R5 cnt1 polarity while unselected no effect", A_REQ, 8'h00);
    wr(A_EDGE, 8'h2D); step();
    chk_reg("R6 source switch raises shared request", A_REQ, 8'h10);
    clr_all();
    @(negedge clk) tmr_evt = 1;
    @(negedge clk) tmr_evt = 0; step();
    chk_reg("R5 timer ignored while pin selected", A_REQ, 8'h00);
    @(negedge clk) pin_cnt1 = 1; step();
    chk_reg("R5 cnt1 rise ignored in falling mode", A_REQ, 8'h00);
    @(negedge clk) pin_cnt1 = 0; step();
    chk_reg("R5 cnt1 falling edge", A_REQ, 8'h10);
    clr_all();

    // latch points (interrupt 2 in falling mode)
    @(negedge clk) pin_int2 = 1; step();
    @(negedge clk) pin_int2 = 0; settle();
    chk_reg("R7 staged event not yet latched", A_REQ, 8'h00);
    @(negedge clk) cyc_last = 1;
    @(negedge clk) cyc_last = 0;
    chk_reg("R7 early event latched at first point", A_REQ, 8'h04);
    clr_all();

    @(negedge clk) pin_int2 = 1; step();
    @(negedge clk) pin_int2 = 0;
    @(negedge clk);
    @(negedge clk) cyc_last = 1;
    @(negedge clk) cyc_last = 0;
    chk_reg("R7 final-clock event held past first point", A_REQ, 8'h00);
    @(negedge clk) cyc_start = 1;
    @(negedge clk) cyc_start = 0;
    chk_reg("R7 final-clock event latched at second point", A_REQ, 8'h04);
    clr_all();

    @(negedge clk) pin_int2 = 1; step();
    early_latch = 1;
    @(negedge clk) pin_int2 = 0;
    @(negedge clk);
    @(negedge clk) cyc_last = 1;
    @(negedge clk) cyc_last = 0;
    chk_reg("R7 early_latch takes final-clock event at first point", A_REQ, 8'h04);
    early_latch = 0;
    clr_all();

    // priority, masking and acknowledge
    @(negedge clk) pin_int1_b = 0; settle();
    @(negedge clk) pin_int1_b = 1; settle();
    @(negedge clk) pin_int2 = 1; settle();
    @(negedge clk) pin_int2 = 0; step();
    chk_reg("R9 disabled requests still visible", A_REQ, 8'h06);
    chk_irq("R9 disabled requests not pending", 1'b0, 3'd0);
    wr(A_EN, 8'h1F);
    chk_irq("R9 lowest index reported", 1'b1, 3'd1);
    ack();
    chk_reg("R10 ack clears only reported source", A_REQ, 8'h04);
    chk_irq("R10 next source reported", 1'b1, 3'd2);
    ack();
    chk_reg("R10 second ack clears remaining", A_REQ, 8'h00);
    chk_irq("R10 nothing pending", 1'b0, 3'd0);

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (R1-path timeout): actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule